// File: doc/BRIEF.md
# DMA Channel Transfer Engine

This block moves one element per granted request for a four-channel DMA controller that uses an external page extension. A separate register file keeps each channel's mode byte, current and base address, current and base count and page byte, and shows them to the engine as flat input vectors. The engine arbitrates among the requesting channels and decodes the winner's mode byte. It forms a 24-bit physical address and then runs one memory cycle on a valid/ready port, or no memory cycle at all for a verify transfer. It then sends the stepped address and count back to the register file as a one-cycle writeback strobe, along with any status and mask changes.

A request is looked at only while the engine is idle, and each grant moves exactly one element. When the count reaches zero, the channel's done status bit is set and its pending-request status bit is cleared. A channel with autoinit reloads its current address and count from the base copies. A channel without autoinit masks itself. A parameter selects the 16-bit controller variant, in which the current address counts words and is shifted left by one when the physical address is formed.

Top module: `dma_xfer_engine`

## Requirements
- R1: When bit 2 of `ctrl_cmd` is 1, no request is granted: no memory cycle, no writeback and no unsupported flag.
- R2: Channels whose `chan_mask` bit is 1 are ignored. Among the remaining requesting channels, the lowest channel number wins.
- R3: The physical address is formed from the page and current address of the winning channel. In byte mode (`WORD_MODE`=0) it is `{page, addr}`. In word mode it is `(page << 16) | (addr << 1)`, 24 bits wide.
- R4: Mode bits 3:2 select the transfer type. Value 1 drives a memory cycle with `mem_write`=1. Value 2 drives a memory cycle with `mem_write`=0. Value 0 (verify) makes no memory cycle but still produces a writeback.
- R5: Only mode bits 7:6 = 01 (single) transfer. Values 00, 10 and 11, or a transfer type of 3, pulse `unsupported` for one cycle and produce no memory cycle and no writeback.
- R6: `mem_valid` stays high with a stable address and direction until `mem_ready` is sampled high. `wb_valid` follows in the next cycle.
- R7: Each element writes back the count minus one. The address steps by one, downward when mode bit 5 is 1 and upward otherwise. It wraps within 16 bits and leaves the page unchanged.
- R8: When the decremented count is zero, the writeback pulses `stat_set` bit [channel] and `stat_clr` bit [channel+4]. Otherwise both stay zero.
- R9: At terminal count with mode bit 4 (autoinit) set, the writeback carries the base address and base count, and `mask_set` stays zero.
- R10: At terminal count without autoinit, `mask_set` bit [channel] pulses, and the writeback carries the stepped address and a count of zero.
- R11: A granted channel whose current count is already zero makes no memory cycle, no writeback and no unsupported flag.
- R12: After reset, `mem_valid`, `wb_valid`, `unsupported`, `stat_set`, `stat_clr` and `mask_set` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_req | input | NCH | Per-channel transfer request |
| ctrl_cmd | input | 8 | Command byte; bit 2 disables the controller |
| chan_mask | input | NCH | Per-channel mask bits |
| chan_mode | input | 8*NCH | Mode byte per channel |
| cur_addr | input | ADDR_W*NCH | Current address per channel |
| cur_cnt | input | CNT_W*NCH | Current count per channel |
| base_addr | input | ADDR_W*NCH | Base address per channel |
| base_cnt | input | CNT_W*NCH | Base count per channel |
| page | input | PAGE_W*NCH | Page byte per channel |
| mem_valid | output | 1 | Memory cycle request |
| mem_write | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | PAGE_W+ADDR_W | Physical address of the element |
| mem_ready | input | 1 | Memory accepts the cycle |
| wb_valid | output | 1 | Writeback strobe for the channel registers |
| wb_chan | output | log2(NCH) | Channel being written back |
| wb_addr | output | ADDR_W | New current address |
| wb_cnt | output | CNT_W | New current count |
| stat_set | output | 2*NCH | Status bits to set |
| stat_clr | output | 2*NCH | Status bits to clear |
| mask_set | output | NCH | Mask bits to set |
| unsupported | output | 1 | Pulse on a rejected mode or transfer type |

## Verification
The main transfer path is tried with several stimuli: an upward read with a slow memory, a downward write, a verify transfer, and an upward step from address FFFF. These show whether the direction bit, the transfer type and the 16-bit wrap are each handled on their own. A second instance in word mode sees the same stimulus, so a shift or page-merge error shows up as a different address from the byte-mode one. Terminal count is tried with and without autoinit, which separates the reload from the self-mask. Mixed request and mask patterns show the priority order. Disable, zero count, non-single modes and the illegal transfer type each check that nothing leaves the ports.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;

    localparam int CMD_DISABLE_BIT = 2;

    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        XT_VERIFY = 2'd0,
        XT_TOMEM  = 2'd1,
        XT_FROMMEM = 2'd2,
        XT_BAD    = 2'd3
    } xfer_e;

    typedef struct packed {
        op_mode_e op;
        logic     down;
        logic     autoinit;
        xfer_e    xt;
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_BUSY = 2'd1,
        S_WB   = 2'd2
    } eng_state_e;

    function automatic mode_t decode_mode(input logic [7:2] m);
        mode_t d;
        d.op       = op_mode_e'(m[7:6]);
        d.down     = m[5];
        d.autoinit = m[4];
        d.xt       = xfer_e'(m[3:2]);
        return d;
    endfunction

endpackage

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
    parameter int N    = 4,
    parameter int IDXW = 2
) (
    input  logic [N-1:0]    req,
    output logic [IDXW-1:0] win,
    output logic            any
);
    always_comb begin
        win = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                win = IDXW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_phys_addr.sv
module dma_phys_addr #(
    parameter int ADDR_W    = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0
) (
    input  logic [PAGE_W-1:0]        page,
    input  logic [ADDR_W-1:0]        addr,
    output logic [PAGE_W+ADDR_W-1:0] phys
);
    localparam int PHYS_W = PAGE_W + ADDR_W;

    generate
        if (WORD_MODE) begin : g_word
            assign phys = {page, {ADDR_W{1'b0}}} | (PHYS_W'(addr) << 1);
        end else begin : g_byte
            assign phys = {page, addr};
        end
    endgenerate
endmodule

// File: rtl/dma_elem_step.sv
module dma_elem_step #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [CNT_W-1:0]  base_c,
    input  logic              down,
    input  logic              autoinit,
    output logic [ADDR_W-1:0] nxt_addr,
    output logic [CNT_W-1:0]  nxt_cnt,
    output logic              tc
);
    logic [ADDR_W-1:0] stepped;
    logic [CNT_W-1:0]  less;

    always_comb begin
        stepped = down ? addr - ADDR_W'(1) : addr + ADDR_W'(1);
        less    = cnt - CNT_W'(1);
        tc      = (less == '0);
        if (tc && autoinit) begin
            nxt_addr = base_a;
            nxt_cnt  = base_c;
        end else begin
            nxt_addr = stepped;
            nxt_cnt  = less;
        end
    end
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_eng_pkg::*;
#(
    parameter int NCH       = 4,
    parameter int ADDR_W    = 16,
    parameter int CNT_W     = 16,
    parameter int PAGE_W    = 8,
    parameter bit WORD_MODE = 1'b0,
    parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NCH-1:0]             chan_req,
    input  logic [7:0]                 ctrl_cmd,
    input  logic [NCH-1:0]             chan_mask,
    input  logic [8*NCH-1:0]           chan_mode,
    input  logic [ADDR_W*NCH-1:0]      cur_addr,
    input  logic [CNT_W*NCH-1:0]       cur_cnt,
    input  logic [ADDR_W*NCH-1:0]      base_addr,
    input  logic [CNT_W*NCH-1:0]       base_cnt,
    input  logic [PAGE_W*NCH-1:0]      page,
    output logic                       mem_valid,
    output logic                       mem_write,
    output logic [PAGE_W+ADDR_W-1:0]   mem_addr,
    input  logic                       mem_ready,
    output logic                       wb_valid,
    output logic [CH_W-1:0]            wb_chan,
    output logic [ADDR_W-1:0]          wb_addr,
    output logic [CNT_W-1:0]           wb_cnt,
    output logic [2*NCH-1:0]           stat_set,
    output logic [2*NCH-1:0]           stat_clr,
    output logic [NCH-1:0]             mask_set,
    output logic                       unsupported
);
    localparam int PHYS_W = PAGE_W + ADDR_W;

    // Eligible requests: enabled controller, unmasked channel
    logic [NCH-1:0] eligible;
    logic [CH_W-1:0] win;
    logic            win_any;

    assign eligible = chan_req & ~chan_mask & {NCH{~ctrl_cmd[CMD_DISABLE_BIT]}};

    dma_prio_arb #(.N(NCH), .IDXW(CH_W)) u_arb (
        .req (eligible),
        .win (win),
        .any (win_any)
    );

    // Command bits other than the disable bit play no part here
    logic unused_cmd;
    assign unused_cmd = ^{ctrl_cmd[7:CMD_DISABLE_BIT+1], ctrl_cmd[CMD_DISABLE_BIT-1:0]};

    // Per-channel mode view; low two mode bits only address the register file
    logic [7:2] mode_hi [NCH];
    logic [NCH-1:0] unused_mode_lo;
    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_mode
            assign mode_hi[g]        = chan_mode[8*g+2 +: 6];
            assign unused_mode_lo[g] = ^chan_mode[8*g +: 2];
        end
    endgenerate

    // Winner's registers
    mode_t               wm;
    logic [ADDR_W-1:0]   w_addr, w_base_a;
    logic [CNT_W-1:0]    w_cnt, w_base_c;
    logic [PAGE_W-1:0]   w_page;
    logic                w_reject, w_empty;

    always_comb begin
        wm       = decode_mode(mode_hi[win]);
        w_addr   = cur_addr[ADDR_W*win +: ADDR_W];
        w_cnt    = cur_cnt[CNT_W*win +: CNT_W];
        w_base_a = base_addr[ADDR_W*win +: ADDR_W];
        w_base_c = base_cnt[CNT_W*win +: CNT_W];
        w_page   = page[PAGE_W*win +: PAGE_W];
        w_reject = (wm.op != OP_SINGLE) || (wm.xt == XT_BAD);
        w_empty  = (w_cnt == '0);
    end

    logic [PHYS_W-1:0] w_phys;
    logic [ADDR_W-1:0] w_nxt_addr;
    logic [CNT_W-1:0]  w_nxt_cnt;
    logic              w_tc;

    dma_phys_addr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_MODE(WORD_MODE)) u_pa (
        .page (w_page),
        .addr (w_addr),
        .phys (w_phys)
    );

    dma_elem_step #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_step (
        .addr     (w_addr),
        .cnt      (w_cnt),
        .base_a   (w_base_a),
        .base_c   (w_base_c),
        .down     (wm.down),
        .autoinit (wm.autoinit),
        .nxt_addr (w_nxt_addr),
        .nxt_cnt  (w_nxt_cnt),
        .tc       (w_tc)
    );

    // Latched job
    eng_state_e        st_q;
    logic [CH_W-1:0]   job_ch;
    logic [PHYS_W-1:0] job_phys;
    logic              job_wr;
    logic [ADDR_W-1:0] job_addr;
    logic [CNT_W-1:0]  job_cnt;
    logic              job_tc;
    logic              job_auto;
    logic              unsup_q;
    logic              idle_w;

    assign idle_w = (st_q == S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= S_IDLE;
            job_ch   <= '0;
            job_phys <= '0;
            job_wr   <= 1'b0;
            job_addr <= '0;
            job_cnt  <= '0;
            job_tc   <= 1'b0;
            job_auto <= 1'b0;
            unsup_q  <= 1'b0;
        end else begin
            unsup_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (win_any) begin
                        if (w_reject) begin
                            unsup_q <= 1'b1;
                        end else if (!w_empty) begin
                            job_ch   <= win;
                            job_phys <= w_phys;
                            job_wr   <= (wm.xt == XT_TOMEM);
                            job_addr <= w_nxt_addr;
                            job_cnt  <= w_nxt_cnt;
                            job_tc   <= w_tc;
                            job_auto <= wm.autoinit;
                            st_q     <= (wm.xt == XT_VERIFY) ? S_WB : S_BUSY;
                        end
                    end
                end
                S_BUSY: begin
                    if (mem_ready) st_q <= S_WB;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    logic [NCH-1:0] ch_oh;
    logic           tc_act;

    assign ch_oh  = NCH'(1) << job_ch;
    assign tc_act = (st_q == S_WB) && job_tc;

    assign mem_valid   = (st_q == S_BUSY);
    assign mem_write   = mem_valid && job_wr;
    assign mem_addr    = job_phys;
    assign wb_valid    = (st_q == S_WB);
    assign wb_chan     = job_ch;
    assign wb_addr     = job_addr;
    assign wb_cnt      = job_cnt;
    assign stat_set    = tc_act ? {{NCH{1'b0}}, ch_oh} : '0;
    assign stat_clr    = tc_act ? {ch_oh, {NCH{1'b0}}} : '0;
    assign mask_set    = (tc_act && !job_auto) ? ch_oh : '0;
    assign unsupported = unsup_q;

endmodule

// File: rtl/dma_xfer_engine_chk.sv
module dma_xfer_engine_chk #(
    parameter int NCH    = 4,
    parameter int PHYS_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              eng_idle,
    input logic              disable_in,
    input logic              mem_valid,
    input logic              mem_write,
    input logic [PHYS_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              wb_valid,
    input logic [2*NCH-1:0]  stat_set,
    input logic [2*NCH-1:0]  stat_clr,
    input logic [NCH-1:0]    mask_set,
    input logic              unsupported
);
    // R1
    disabled_no_start_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_idle && disable_in) |=> (!mem_valid && !wb_valid));

    // R5
    reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        unsupported |-> (!mem_valid && !wb_valid));

    // R6
    hold_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

    // R6
    wb_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready) |=> (wb_valid && !mem_valid));

    // R8
    status_with_wb_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_set != '0) |-> (wb_valid && $onehot0(stat_set) && (stat_set[NCH-1:0] << NCH) == stat_clr));

    // R10
    mask_only_at_tc_chk: assert property (@(posedge clk) disable iff (rst)
        (mask_set != '0) |-> (stat_set[NCH-1:0] == mask_set));

    // R12
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_valid && !wb_valid && !unsupported));
endmodule

bind dma_xfer_engine dma_xfer_engine_chk #(.NCH(NCH), .PHYS_W(PAGE_W + ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .eng_idle    (idle_w),
    .disable_in  (ctrl_cmd[2]),
    .mem_valid   (mem_valid),
    .mem_write   (mem_write),
    .mem_addr    (mem_addr),
    .mem_ready   (mem_ready),
    .wb_valid    (wb_valid),
    .stat_set    (stat_set),
    .stat_clr    (stat_clr),
    .mask_set    (mask_set),
    .unsupported (unsupported)
);

// File: tb/tb_dma_xfer_engine.sv
module tb_dma_xfer_engine;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  chan_req = '0;
    logic [7:0]  ctrl_cmd = '0;
    logic [3:0]  chan_mask = '0;
    logic [31:0] chan_mode = '0;
    logic [63:0] cur_addr = '0, cur_cnt = '0, base_addr = '0, base_cnt = '0;
    logic [31:0] page = '0;
    logic        mem_ready = 1'b0;

    logic        mem_valid, mem_write, wb_valid, unsupported;
    logic [23:0] mem_addr;
    logic [1:0]  wb_chan;
    logic [15:0] wb_addr, wb_cnt;
    logic [7:0]  stat_set, stat_clr;
    logic [3:0]  mask_set;

    logic        w_mem_valid, w_mem_write, w_wb_valid, w_unsupported;
    logic [23:0] w_mem_addr;
    logic [1:0]  w_wb_chan;
    logic [15:0] w_wb_addr, w_wb_cnt;
    logic [7:0]  w_stat_set, w_stat_clr;
    logic [3:0]  w_mask_set;

    always #4 clk = ~clk;

    dma_xfer_engine #(.NCH(NCH)) dut (
        .clk(clk), .rst(rst), .chan_req(chan_req), .ctrl_cmd(ctrl_cmd),
        .chan_mask(chan_mask), .chan_mode(chan_mode), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt), .page(page),
        .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
        .mem_ready(mem_ready), .wb_valid(wb_valid), .wb_chan(wb_chan),
        .wb_addr(wb_addr), .wb_cnt(wb_cnt), .stat_set(stat_set), .stat_clr(stat_clr),
        .mask_set(mask_set), .unsupported(unsupported)
    );

    dma_xfer_engine #(.NCH(NCH), .WORD_MODE(1'b1)) dut_w (
        .clk(clk), .rst(rst), .chan_req(chan_req), .ctrl_cmd(ctrl_cmd),
        .chan_mask(chan_mask), .chan_mode(chan_mode), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt), .page(page),
        .mem_valid(w_mem_valid), .mem_write(w_mem_write), .mem_addr(w_mem_addr),
        .mem_ready(mem_ready), .wb_valid(w_wb_valid), .wb_chan(w_wb_chan),
        .wb_addr(w_wb_addr), .wb_cnt(w_wb_cnt), .stat_set(w_stat_set), .stat_clr(w_stat_clr),
        .mask_set(w_mask_set), .unsupported(w_unsupported)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Observations of one request
    int          o_mem, o_wb, o_uns;
    logic        o_wr;
    logic [23:0] o_addr, o_waddr;
    logic [1:0]  o_ch;
    logic [15:0] o_a, o_c;
    logic [7:0]  o_ss, o_sc;
    logic [3:0]  o_ms;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_chan(input int ch, input logic [7:0] md, input logic [15:0] a,
                            input logic [15:0] c, input logic [15:0] ba,
                            input logic [15:0] bc, input logic [7:0] pg);
        chan_mode[ch*8 +: 8]  = md;
        cur_addr[ch*16 +: 16] = a;
        cur_cnt[ch*16 +: 16]  = c;
        base_addr[ch*16 +: 16] = ba;
        base_cnt[ch*16 +: 16] = bc;
        page[ch*8 +: 8]       = pg;
    endtask

    task automatic run_req(input logic [3:0] rq, input int rdly);
        int waitn;
        o_mem = 0; o_wb = 0; o_uns = 0; o_wr = 1'b0;
        o_addr = '0; o_waddr = '0; o_ch = '0; o_a = '0; o_c = '0;
        o_ss = '0; o_sc = '0; o_ms = '0;
        waitn = 0;
        @(negedge clk);
        chan_req = rq;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chan_req = '0;
            if (unsupported) o_uns++;
            if (mem_valid) begin
                if (o_mem == 0) begin
                    o_addr = mem_addr; o_wr = mem_write; o_waddr = w_mem_addr;
                end
                o_mem++;
                if (waitn == rdly) mem_ready = 1'b1;
                else waitn++;
            end else begin
                mem_ready = 1'b0;
            end
            if (wb_valid) begin
                o_wb++; o_ch = wb_chan; o_a = wb_addr; o_c = wb_cnt;
                o_ss = stat_set; o_sc = stat_clr; o_ms = mask_set;
            end
        end
    endtask

    task automatic t_reset;
        check("R12 mem_valid", 32'(mem_valid), 0);
        check("R12 wb_valid", 32'(wb_valid), 0);
        check("R12 unsupported", 32'(unsupported), 0);
        check("R12 strobes", {stat_set, stat_clr, 4'h0, mask_set}, 0);
    endtask

    task automatic t_read_up;
        set_chan(1, 8'h48, 16'h1234, 16'd5, 16'h0, 16'h0, 8'h3A);
        run_req(4'b0010, 2);
        check("R6 held cycles", o_mem, 3);
        check("R4 read dir", 32'(o_wr), 0);
        check("R3 byte addr", 32'(o_addr), 32'h3A1234);
        check("R3 word addr", 32'(o_waddr), 32'h3A2468);
        check("R7 addr up", 32'(o_a), 32'h1235);
        check("R7 cnt", 32'(o_c), 4);
        check("R8 no tc", {o_ss, o_sc}, 0);
        check("R6 wb once", o_wb, 1);
    endtask

    task automatic t_write_down;
        set_chan(2, 8'h64, 16'h8000, 16'd3, 16'h0, 16'h0, 8'h10);
        run_req(4'b0100, 0);
        check("R4 write dir", 32'(o_wr), 1);
        check("R3 byte addr", 32'(o_addr), 32'h108000);
        check("R3 word addr", 32'(o_waddr), 32'h110000);
        check("R7 addr down", 32'(o_a), 32'h7FFF);
        check("R7 cnt", 32'(o_c), 2);
    endtask

    task automatic t_verify;
        set_chan(3, 8'h40, 16'h0200, 16'd9, 16'h0, 16'h0, 8'h01);
        run_req(4'b1000, 0);
        check("R4 verify no mem", o_mem, 0);
        check("R4 verify wb", o_wb, 1);
        check("R4 verify chan", 32'(o_ch), 3);
        check("R7 verify addr", 32'(o_a), 32'h0201);
    endtask

    task automatic t_wrap;
        set_chan(1, 8'h48, 16'hFFFF, 16'd7, 16'h0, 16'h0, 8'h22);
        run_req(4'b0010, 1);
        check("R3 byte addr wrapcase", 32'(o_addr), 32'h22FFFF);
        check("R3 word addr wrapcase", 32'(o_waddr), 32'h23FFFE);
        check("R7 wrap addr", 32'(o_a), 32'h0000);
    endtask

    task automatic t_tc_auto;
        set_chan(0, 8'h58, 16'h4321, 16'd1, 16'h4000, 16'h0010, 8'h05);
        run_req(4'b0001, 0);
        check("R9 reload addr", 32'(o_a), 32'h4000);
        check("R9 reload cnt", 32'(o_c), 32'h0010);
        check("R8 stat_set", 32'(o_ss), 32'h01);
        check("R8 stat_clr", 32'(o_sc), 32'h10);
        check("R9 no mask", 32'(o_ms), 0);
    endtask

    task automatic t_tc_mask;
        set_chan(2, 8'h44, 16'h0100, 16'd1, 16'h7777, 16'h0033, 8'h00);
        run_req(4'b0100, 0);
        check("R10 mask_set", 32'(o_ms), 32'h4);
        check("R10 addr", 32'(o_a), 32'h0101);
        check("R10 cnt", 32'(o_c), 0);
        check("R8 stat_set ch2", 32'(o_ss), 32'h04);
        check("R8 stat_clr ch2", 32'(o_sc), 32'h40);
    endtask

    task automatic t_disable;
        set_chan(1, 8'h48, 16'h0010, 16'd4, 16'h0, 16'h0, 8'h00);
        ctrl_cmd = 8'h04;
        run_req(4'b0010, 0);
        check("R1 no mem", o_mem, 0);
        check("R1 no wb", o_wb, 0);
        check("R1 no flag", o_uns, 0);
        ctrl_cmd = 8'h00;
    endtask

    task automatic t_priority;
        set_chan(0, 8'h48, 16'h0000, 16'd4, 16'h0, 16'h0, 8'h00);
        set_chan(1, 8'h48, 16'h1000, 16'd4, 16'h0, 16'h0, 8'h00);
        set_chan(2, 8'h48, 16'h2000, 16'd4, 16'h0, 16'h0, 8'h00);
        set_chan(3, 8'h48, 16'h3000, 16'd4, 16'h0, 16'h0, 8'h00);
        chan_mask = 4'b0001;
        run_req(4'b0011, 0);
        check("R2 masked ch0 skipped", 32'(o_ch), 1);
        chan_mask = 4'b0000;
        run_req(4'b1100, 0);
        check("R2 ch2 over ch3", 32'(o_ch), 2);
        run_req(4'b1111, 0);
        check("R2 ch0 highest", 32'(o_ch), 0);
        chan_mask = 4'b1111;
        run_req(4'b1111, 0);
        check("R2 all masked", o_wb, 0);
        chan_mask = 4'b0000;
    endtask

    task automatic t_unsupported;
        set_chan(1, 8'h88, 16'h0010, 16'd4, 16'h0, 16'h0, 8'h00);
        run_req(4'b0010, 0);
        check("R5 block flag", o_uns, 1);
        check("R5 block no mem", o_mem + o_wb, 0);
        set_chan(1, 8'h08, 16'h0010, 16'd4, 16'h0, 16'h0, 8'h00);
        run_req(4'b0010, 0);
        check("R5 demand flag", o_uns, 1);
        set_chan(1, 8'hC8, 16'h0010, 16'd4, 16'h0, 16'h0, 8'h00);
        run_req(4'b0010, 0);
        check("R5 cascade flag", o_uns, 1);
        set_chan(1, 8'h4C, 16'h0010, 16'd4, 16'h0, 16'h0, 8'h00);
        run_req(4'b0010, 0);
        check("R5 type3 flag", o_uns, 1);
        check("R5 type3 quiet", o_mem + o_wb, 0);
    endtask

    task automatic t_zero;
        set_chan(3, 8'h44, 16'h0050, 16'd0, 16'h0, 16'h0, 8'h00);
        run_req(4'b1000, 0);
        check("R11 no mem", o_mem, 0);
        check("R11 no wb", o_wb, 0);
        check("R11 no flag", o_uns, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_read_up();
        t_write_down();
        t_verify();
        t_wrap();
        t_tc_auto();
        t_tc_mask();
        t_disable();
        t_priority();
        t_unsupported();
        t_zero();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule